// File: doc/BRIEF.md
# Posted-Write PCI Target Front End

This block is the target side of a PCI bridge that only takes memory writes. An external master starts a write burst. The block checks the command and the address window, claims the cycle with medium decode timing, and then accepts every data phase without wait states. It posts the burst into two FIFOs. One holds one entry per burst with the starting word address. The other holds one entry per data phase with the data word, its byte enables and an end-of-burst marker.

When the block has no room, it pushes back on the bus. If either FIFO is full when the claim decision is made, the master gets a retry. If the data FIFO fills in the middle of a burst, the master gets a disconnect.

On the memory side, the block raises a request a fixed number of clocks after posted data first appears. This delay stands in for a clock-crossing synchronizer. The block then waits for a grant from a memory arbiter, which may take any number of clocks. After the grant it presents entries one at a time on a valid/accept handshake, each at its computed word address.

Top module: `pci_post_wr_tgt`

## Requirements
- R1: After reset, every active-low bus output (`devsel_n`, `trdy_n`, `stop_n`) is high, and `mem_req` and `mem_valid` are low.
- R2: A claimed cycle asserts `devsel_n` exactly two clocks after the clock in which `frame_n` first goes low.
- R3: The claim decision is made one clock after the address phase. If the address FIFO or the data FIFO is full at that point, the block asserts `stop_n` with `trdy_n` high, which is a retry. It stores nothing for that cycle.
- R4: If neither FIFO is full, `trdy_n` goes low together with `devsel_n`. It stays low for every data phase of the burst and is never raised to insert a wait state.
- R5: The block disconnects when an accepted phase fills the data FIFO and `frame_n` is still low. On the next clock `trdy_n` goes high and `stop_n` goes low, so no further data is taken.
- R6: A data phase is stored only on a clock where both `irdy_n` and `trdy_n` are low. A master wait state (`irdy_n` high) stores nothing.
- R7: Each stored phase keeps the 32-bit `ad` value and the byte enables as active-high bits, `mem_be[i] = ~cbe_n[i]`. Both are presented unchanged on `mem_data` and `mem_be`.
- R8: `mem_req` rises three clocks after the clock edge that stores the first phase into an empty data FIFO. It then stays high until the data FIFO is empty.
- R9: No entry is presented (`mem_valid`) before `mem_gnt` has been seen with `mem_req` high. Posted data waits for as long as the grant is delayed.
- R10: Entries leave in arrival order. A burst's first word goes out at its start address with bits [1:0] zero, and each later word goes out 4 bytes higher. While `mem_valid` is high and `mem_accept` is low, the address and data hold.
- R11: The block holds `stop_n` low until it samples `frame_n` high. One clock after sampling `frame_n` high on the final phase, or while stopping, it releases `devsel_n`, `trdy_n` and `stop_n`. It then accepts the next transaction.
- R12: A cycle is claimed only if `cbe_n` is 4'b0111 (memory write) during the address phase and `(ad & WIN_MASK) == WIN_BASE`. Any other cycle never asserts `devsel_n` and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Cycle frame from the master, active low |
| irdy_n | input | 1 | Master ready, active low |
| ad | input | 32 | Multiplexed address/data |
| cbe_n | input | 4 | Command in the address phase, byte enables (active low) in data phases |
| devsel_n | output | 1 | Target claims the cycle, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target requests termination, active low |
| mem_req | output | 1 | Request to the memory arbiter |
| mem_gnt | input | 1 | Grant from the memory arbiter |
| mem_valid | output | 1 | A posted entry is presented |
| mem_accept | input | 1 | Memory side takes the presented entry |
| mem_addr | output | 32 | Byte address of the presented word |
| mem_data | output | 32 | Presented data word |
| mem_be | output | 4 | Presented byte enables, active high |

## Verification
The bench goes after the clocks where the FIFO limits meet the bus.

- A burst longer than the data FIFO runs while the grant is held off. A design that checked fullness one clock late would overwrite an entry. One that did not disconnect would keep `trdy_n` low against a full FIFO.
- A burst starts against a full data FIFO, and separately against a full address FIFO while the data FIFO still has room. A wrong design would claim with `trdy_n` instead of retrying, or would check only one of the two FIFOs.
- The master inserts wait states, and the memory side stalls. A wrong design would store the word on the wrong clock, or would lose an address increment across a stall.
- Non-write commands and out-of-window addresses are issued. A careless decoder would claim them.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BE_W   = 4;
    localparam int WORD_W = ADDR_W - 2;

    localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_XFER,
        ST_RETRY,
        ST_DISC,
        ST_IGNORE
    } tgt_state_e;

    // one entry per data phase
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
        logic              last;
    } dat_ent_t;

    // one entry per burst
    typedef struct packed {
        logic [WORD_W-1:0] word_addr;
    } adr_ent_t;

    function automatic logic win_hit(input logic [ADDR_W-1:0] addr,
                                     input logic [ADDR_W-1:0] base,
                                     input logic [ADDR_W-1:0] mask);
        return (addr & mask) == base;
    endfunction

endpackage

// File: rtl/pwt_fifo.sv
module pwt_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CNT_W-1:0] level
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign do_push = push && (cnt_q != CNT_W'(DEPTH));
    assign do_pop  = pop  && (cnt_q != '0);
    assign rdata   = mem[rd_ptr];
    assign level   = cnt_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

endmodule

// File: rtl/pwt_tgt_fsm.sv
module pwt_tgt_fsm
    import pwt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h1000_0000,
    parameter logic [ADDR_W-1:0] WIN_MASK = 32'hF000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic [ADDR_W-1:0] ad,
    input  logic [3:0]        cbe_n,
    input  logic              afifo_full,
    input  logic              dfifo_full,
    input  logic              dfifo_one_left,
    input  logic              dfifo_pop,
    output logic              devsel_n,
    output logic              trdy_n,
    output logic              stop_n,
    output logic              a_push,
    output adr_ent_t          a_wdata,
    output logic              d_push,
    output dat_ent_t          d_wdata
);

    tgt_state_e        state_q, state_nx;
    logic              frame_q;
    logic [WORD_W-1:0] addr_q;
    logic              d_last;
    logic              start;

    assign start = !frame_n && frame_q;

    always_comb begin
        state_nx = state_q;
        a_push   = 1'b0;
        d_push   = 1'b0;
        d_last   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (cbe_n == CMD_MEM_WRITE && win_hit(ad, WIN_BASE, WIN_MASK))
                        state_nx = ST_DECODE;
                    else
                        state_nx = ST_IGNORE;
                end
            end
            ST_DECODE: begin
                if (afifo_full || dfifo_full) begin
                    state_nx = ST_RETRY;
                end else begin
                    state_nx = ST_XFER;
                    a_push   = 1'b1;
                end
            end
            ST_XFER: begin
                if (!irdy_n) begin
                    d_push = 1'b1;
                    if (frame_n) begin
                        d_last   = 1'b1;
                        state_nx = ST_IDLE;
                    end else if (dfifo_one_left && !dfifo_pop) begin
                        d_last   = 1'b1;
                        state_nx = ST_DISC;
                    end
                end
            end
            ST_RETRY, ST_DISC: begin
                if (frame_n) state_nx = ST_IDLE;
            end
            ST_IGNORE: begin
                if (frame_n && irdy_n) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            frame_q <= 1'b1;
            addr_q  <= '0;
        end else begin
            state_q <= state_nx;
            frame_q <= frame_n;
            if (state_q == ST_IDLE && start) addr_q <= ad[ADDR_W-1:2];
        end
    end

    assign devsel_n = !(state_q == ST_XFER || state_q == ST_RETRY || state_q == ST_DISC);
    assign trdy_n   = !(state_q == ST_XFER);
    assign stop_n   = !(state_q == ST_RETRY || state_q == ST_DISC);

    assign a_wdata.word_addr = addr_q;
    assign d_wdata.data      = ad;
    assign d_wdata.be        = ~cbe_n;
    assign d_wdata.last      = d_last;

endmodule

// File: rtl/pwt_drain.sv
module pwt_drain
    import pwt_pkg::*;
#(
    parameter int SYNC_STAGES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              d_empty,
    input  adr_ent_t          a_head,
    input  dat_ent_t          d_head,
    input  logic              mem_gnt,
    input  logic              mem_accept,
    output logic              mem_req,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [BE_W-1:0]   mem_be,
    output logic              d_pop,
    output logic              a_pop
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   held_q;
    logic                   granted_q;
    logic [WORD_W-1:0]      offset_q;

    // models the synchronizer latency of "data present"
    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= !d_empty;
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], !d_empty};
            end
        end
    endgenerate

    assign mem_req   = !d_empty && (sync_q[SYNC_STAGES-1] || held_q);
    assign mem_valid = granted_q && !d_empty;
    assign d_pop     = mem_valid && mem_accept;
    assign a_pop     = d_pop && d_head.last;
    assign mem_addr  = {a_head.word_addr + offset_q, 2'b00};
    assign mem_data  = d_head.data;
    assign mem_be    = d_head.be;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q    <= 1'b0;
            granted_q <= 1'b0;
            offset_q  <= '0;
        end else begin
            held_q <= mem_req;
            if (d_empty)                granted_q <= 1'b0;
            else if (mem_req && mem_gnt) granted_q <= 1'b1;
            if (d_pop) offset_q <= d_head.last ? '0 : offset_q + 1'b1;
        end
    end

endmodule

// File: rtl/pci_post_wr_tgt.sv
module pci_post_wr_tgt
    import pwt_pkg::*;
#(
    parameter int                A_DEPTH     = 4,
    parameter int                D_DEPTH     = 8,
    parameter int                SYNC_STAGES = 3,
    parameter logic [ADDR_W-1:0] WIN_BASE    = 32'h1000_0000,
    parameter logic [ADDR_W-1:0] WIN_MASK    = 32'hF000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic [ADDR_W-1:0] ad,
    input  logic [3:0]        cbe_n,
    output logic              devsel_n,
    output logic              trdy_n,
    output logic              stop_n,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic              mem_valid,
    input  logic              mem_accept,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [BE_W-1:0]   mem_be
);

    localparam int A_CNT_W = $clog2(A_DEPTH + 1);
    localparam int D_CNT_W = $clog2(D_DEPTH + 1);

    adr_ent_t           a_wdata, a_rdata;
    dat_ent_t           d_wdata, d_rdata;
    logic               a_push, a_pop, d_push, d_pop;
    logic [A_CNT_W-1:0] a_level;
    logic [D_CNT_W-1:0] d_level;

    pwt_tgt_fsm #(
        .WIN_BASE (WIN_BASE),
        .WIN_MASK (WIN_MASK)
    ) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .frame_n        (frame_n),
        .irdy_n         (irdy_n),
        .ad             (ad),
        .cbe_n          (cbe_n),
        .afifo_full     (a_level == A_CNT_W'(A_DEPTH)),
        .dfifo_full     (d_level == D_CNT_W'(D_DEPTH)),
        .dfifo_one_left (d_level == D_CNT_W'(D_DEPTH - 1)),
        .dfifo_pop      (d_pop),
        .devsel_n       (devsel_n),
        .trdy_n         (trdy_n),
        .stop_n         (stop_n),
        .a_push         (a_push),
        .a_wdata        (a_wdata),
        .d_push         (d_push),
        .d_wdata        (d_wdata)
    );

    pwt_fifo #(.WIDTH($bits(adr_ent_t)), .DEPTH(A_DEPTH)) u_afifo (
        .clk   (clk),
        .rst   (rst),
        .push  (a_push),
        .wdata (a_wdata),
        .pop   (a_pop),
        .rdata (a_rdata),
        .level (a_level)
    );

    pwt_fifo #(.WIDTH($bits(dat_ent_t)), .DEPTH(D_DEPTH)) u_dfifo (
        .clk   (clk),
        .rst   (rst),
        .push  (d_push),
        .wdata (d_wdata),
        .pop   (d_pop),
        .rdata (d_rdata),
        .level (d_level)
    );

    pwt_drain #(.SYNC_STAGES(SYNC_STAGES)) u_drain (
        .clk        (clk),
        .rst        (rst),
        .d_empty    (d_level == '0),
        .a_head     (a_rdata),
        .d_head     (d_rdata),
        .mem_gnt    (mem_gnt),
        .mem_accept (mem_accept),
        .mem_req    (mem_req),
        .mem_valid  (mem_valid),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .mem_be     (mem_be),
        .d_pop      (d_pop),
        .a_pop      (a_pop)
    );

endmodule

// File: rtl/pwt_checker.sv
module pwt_checker (
    input logic        clk,
    input logic        rst,
    input logic        frame_n,
    input logic        devsel_n,
    input logic        trdy_n,
    input logic        stop_n,
    input logic        mem_req,
    input logic        mem_valid,
    input logic        mem_accept,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_data
);

    a_r2_medium_decode: assert property (@(posedge clk) disable iff (rst)
        $fell(devsel_n) |-> (!$past(frame_n, 2) && $past(frame_n, 3)));

    a_r4_trdy_needs_devsel: assert property (@(posedge clk) disable iff (rst)
        !trdy_n |-> !devsel_n);

    a_r5_no_stop_with_trdy: assert property (@(posedge clk) disable iff (rst)
        !(!trdy_n && !stop_n));

    a_r8_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> mem_req);

    a_r9_valid_needs_req: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> mem_req);

    a_r10_stall_stable: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_accept) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    a_r11_stop_until_frame: assert property (@(posedge clk) disable iff (rst)
        (!stop_n && !frame_n) |=> !stop_n);

endmodule

bind pci_post_wr_tgt pwt_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_n    (frame_n),
    .devsel_n   (devsel_n),
    .trdy_n     (trdy_n),
    .stop_n     (stop_n),
    .mem_req    (mem_req),
    .mem_valid  (mem_valid),
    .mem_accept (mem_accept),
    .mem_addr   (mem_addr),
    .mem_data   (mem_data)
);

// File: tb/pci_post_wr_tgt_bench.sv
`timescale 1ns/1ps
module pci_post_wr_tgt_bench;

    localparam int AD = 4;
    localparam int DD = 8;
    localparam logic [31:0] BASE = 32'h1000_0000;
    localparam logic [31:0] MASK = 32'hF000_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_n = 1'b1, irdy_n = 1'b1;
    logic [31:0] ad = '0;
    logic [3:0] cbe_n = 4'hF;
    logic devsel_n, trdy_n, stop_n, mem_req, mem_valid;
    logic mem_gnt = 1'b0, mem_accept = 1'b1;
    logic [31:0] mem_addr, mem_data;
    logic [3:0] mem_be;

    int checks = 0, fails = 0, cyc = 0, dut_pops = 0;
    bit gnt_on = 1'b0, stall_mode = 1'b0;

    always #2.5 clk = ~clk;

    pci_post_wr_tgt #(.A_DEPTH(AD), .D_DEPTH(DD), .SYNC_STAGES(3),
                      .WIN_BASE(BASE), .WIN_MASK(MASK)) u_pci_post_wr_tgt (
        .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .ad(ad),
        .cbe_n(cbe_n), .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_valid(mem_valid),
        .mem_accept(mem_accept), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_be(mem_be));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // ---------------- behavioural reference model ----------------
    localparam int M_IDLE = 0, M_DEC = 1, M_XFER = 2, M_RETRY = 3, M_DISC = 4, M_IGN = 5;
    int          mst = M_IDLE;
    bit          mframe_q = 1'b1;
    logic [29:0] maddr = '0;
    logic [29:0] aq[$];
    logic [36:0] dq[$];
    logic [2:0]  msync = '0;
    bit          mheld = 1'b0, mgrant = 1'b0;
    int          moff = 0;

    always @(posedge clk) begin
        cyc++;
        if (mem_valid && mem_accept) dut_pops++;
        if (rst) begin
            mst = M_IDLE; mframe_q = 1; aq.delete(); dq.delete();
            msync = '0; mheld = 0; mgrant = 0; moff = 0;
        end else begin
            bit ne, req, fire, pushd;
            int nst;
            logic [36:0] ent;
            ne   = dq.size() > 0;
            req  = ne && (msync[2] || mheld);
            fire = mgrant && ne && mem_accept;
            nst  = mst;
            pushd = 0;
            ent  = '0;
            case (mst)
                M_IDLE: if (!frame_n && mframe_q) begin
                    maddr = ad[31:2];
                    nst = (cbe_n == 4'b0111 && (ad & MASK) == BASE) ? M_DEC : M_IGN;
                end
                M_DEC: if (aq.size() == AD || dq.size() == DD) nst = M_RETRY;
                       else begin nst = M_XFER; aq.push_back(maddr); end
                M_XFER: if (!irdy_n) begin
                    pushd = 1;
                    ent = {ad, ~cbe_n, 1'b0};
                    if (frame_n) begin ent[0] = 1; nst = M_IDLE; end
                    else if (dq.size() == DD - 1 && !fire) begin ent[0] = 1; nst = M_DISC; end
                end
                M_RETRY, M_DISC: if (frame_n) nst = M_IDLE;
                M_IGN: if (frame_n && irdy_n) nst = M_IDLE;
                default: nst = M_IDLE;
            endcase
            if (fire) begin
                logic [36:0] h;
                h = dq.pop_front();
                if (h[0]) begin void'(aq.pop_front()); moff = 0; end
                else moff++;
            end
            if (pushd) dq.push_back(ent);
            msync  = {msync[1:0], ne};
            mheld  = req;
            if (!ne) mgrant = 0;
            else if (req && mem_gnt) mgrant = 1;
            mframe_q = frame_n;
            mst = nst;
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            bit ne;
            ne = dq.size() > 0;
            chk("R2 devsel_n", {31'd0, devsel_n}, {31'd0, !(mst == M_XFER || mst == M_RETRY || mst == M_DISC)});
            chk("R4 trdy_n",   {31'd0, trdy_n},   {31'd0, !(mst == M_XFER)});
            chk("R3 stop_n",   {31'd0, stop_n},   {31'd0, !(mst == M_RETRY || mst == M_DISC)});
            chk("R8 mem_req",  {31'd0, mem_req},  {31'd0, ne && (msync[2] || mheld)});
            chk("R9 mem_valid",{31'd0, mem_valid},{31'd0, mgrant && ne});
            if (mgrant && ne) begin
                chk("R10 mem_addr", mem_addr, {aq[0] + 30'(moff), 2'b00});
                chk("R7 mem_data",  mem_data, dq[0][36:5]);
                chk("R7 mem_be",    {28'd0, mem_be}, {28'd0, dq[0][4:1]});
            end
        end
    end

    // memory-side stimulus
    always @(negedge clk) begin
        mem_gnt    <= gnt_on;
        mem_accept <= stall_mode ? (cyc % 3 != 1) : 1'b1;
    end

    // ---------------- PCI master ----------------
    task automatic pci_write(input logic [31:0] a, input logic [3:0] cmd, input int n,
                             input int wait_every, output int done_n, output bit stopped,
                             output bit saw_devsel, output int dev_lat);
        int i = 0, k = 0, age = 0;
        bit fin = 0, last_irdy = 1, last_trdy = 1;
        done_n = 0; stopped = 0; saw_devsel = 0; dev_lat = -1;
        @(negedge clk);
        frame_n = 0; irdy_n = 1; ad = a; cbe_n = cmd;
        while (!fin) begin
            @(negedge clk);
            age++;
            if (!last_irdy && !last_trdy) i++;
            if (!devsel_n && !saw_devsel) begin saw_devsel = 1; dev_lat = age; end
            if (i == n) begin
                frame_n = 1; irdy_n = 1; fin = 1;
            end else if (!stop_n && trdy_n) begin
                stopped = 1; frame_n = 1; irdy_n = 0;
                @(negedge clk); irdy_n = 1; fin = 1;
            end else if (!saw_devsel && age > 5) begin
                frame_n = 1; irdy_n = 0;
                @(negedge clk); irdy_n = 1; fin = 1;
            end else begin
                bit w;
                w = (frame_n == 0) && wait_every > 0 && (k % wait_every == wait_every - 1);
                k++;
                irdy_n = w;
                if (!w && i == n - 1) frame_n = 1;
                ad = a ^ (32'h0101_0101 * (i + 1)) ^ 32'hA5A5_0000;
                cbe_n = 4'(i * 5 + 3);
            end
            last_irdy = irdy_n; last_trdy = trdy_n;
        end
        done_n = i;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
    end

    initial begin
        int dn, lat, total;
        bit st, sd;
        total = 0;
        repeat (4) @(negedge clk);
        // R1: reset state, sampled while reset is still held
        chk("R1 devsel_n", {31'd0, devsel_n}, 32'd1);
        chk("R1 trdy_n",   {31'd0, trdy_n},   32'd1);
        chk("R1 stop_n",   {31'd0, stop_n},   32'd1);
        chk("R1 mem_req",  {31'd0, mem_req},  32'd0);
        chk("R1 mem_valid",{31'd0, mem_valid},32'd0);
        rst = 0;
        gnt_on = 1;
        settle(3);

        // plain burst
        pci_write(32'h1000_0040, 4'b0111, 4, 0, dn, st, sd, lat);
        chk("R2 devsel latency", lat, 2);
        chk("R4 full burst", dn, 4);
        total += dn;
        settle(20);
        chk("R10 drained", dut_pops, total);

        // master wait states
        pci_write(32'h1000_1000, 4'b0111, 5, 2, dn, st, sd, lat);
        chk("R6 wait-state burst", dn, 5);
        total += dn;
        // single phase, back to back with a stalled memory side
        stall_mode = 1;
        pci_write(32'h1ABC_0004, 4'b0111, 1, 0, dn, st, sd, lat);
        chk("R11 single phase", dn, 1);
        total += dn;
        pci_write(32'h1000_2000, 4'b0111, 6, 3, dn, st, sd, lat);
        total += dn;
        settle(40);
        stall_mode = 0;
        chk("R10 drained under stall", dut_pops, total);

        // ignored cycles
        pci_write(32'h1000_3000, 4'b0110, 2, 0, dn, st, sd, lat);
        chk("R12 wrong command", {31'd0, sd}, 32'd0);
        pci_write(32'h2000_0000, 4'b0111, 2, 0, dn, st, sd, lat);
        chk("R12 outside window", {31'd0, sd}, 32'd0);
        settle(10);
        chk("R12 nothing stored", dut_pops, total);

        // delayed grant
        gnt_on = 0;
        pci_write(32'h1000_4000, 4'b0111, 3, 0, dn, st, sd, lat);
        total += dn;
        settle(30);
        chk("R9 held without grant", dut_pops, total - 3);
        chk("R8 request pending", {31'd0, mem_req}, 32'd1);
        gnt_on = 1;
        settle(20);
        chk("R9 drained after grant", dut_pops, total);

        // disconnect then retry on a full data FIFO
        gnt_on = 0;
        pci_write(32'h1000_5000, 4'b0111, 12, 0, dn, st, sd, lat);
        chk("R5 disconnect count", dn, DD);
        chk("R5 disconnect stop", {31'd0, st}, 32'd1);
        total += dn;
        pci_write(32'h1000_6000, 4'b0111, 2, 0, dn, st, sd, lat);
        chk("R3 retry on data full", dn, 0);
        chk("R3 retry stop", {31'd0, st}, 32'd1);
        gnt_on = 1;
        settle(30);
        chk("R10 drained after disconnect", dut_pops, total);

        // retry on a full address FIFO
        gnt_on = 0;
        for (int b = 0; b < AD; b++) begin
            pci_write(32'h1000_7000 + 32'(b * 64), 4'b0111, 1, 0, dn, st, sd, lat);
            total += dn;
        end
        pci_write(32'h1000_8000, 4'b0111, 1, 0, dn, st, sd, lat);
        chk("R3 retry on address full", dn, 0);
        gnt_on = 1;
        settle(30);
        chk("R10 drained after retry", dut_pops, total);
        pci_write(32'h1000_9000, 4'b0111, 3, 0, dn, st, sd, lat);
        chk("R11 accepts after retry", dn, 3);
        settle(20);
        summary();
    end

endmodule